// File: doc/BRIEF.md
# Nesting Interrupt Controller

This block gathers interrupt requests from a parameterised set of independent, asynchronous sources and hands the processor one request at a time, together with the index of the source to service. Each request line is synchronised and then captured only when a sample strobe is high. A new rising level seen at a strobe sets a per-source pending flag. Software clears that flag by writing the source's clear strobe.

A run-time mode input selects how services relate to each other. Single-level modes let one service run to its end. Multi-level modes let a new request suspend the running service and push it onto a nesting stack. Either kind can order candidates by arrival or by a fixed priority in which a higher index wins.

A global enable gates presentation. It drops by itself each time a request is handed out, and software sets it again. The processor ends each service with an end-of-service strobe. That strobe resumes the most recently suspended service, or returns the controller to idle when nothing is suspended.

Top module: `nest_intc`

## Requirements
- R1: A request line reaches the sampling stage after two flops, and only a high `sample_i` captures it. A line driven high one cycle before a strobe is not yet seen, and without a strobe no pending flag is set.
- R2: A captured rising level sets that source's pending bit. A second capture while the bit is still set leaves the bit set and sets that source's sticky lost bit. A `clr_i` bit clears both the pending bit and the lost bit.
- R3: With `mode_i[0]`=1 (priority modes), the pending source with the highest index is chosen.
- R4: With `mode_i[0]`=0, the source whose request was captured at the earliest strobe is chosen. Sources captured at the same strobe are ordered lowest index first.
- R5: With `mode_i[1]`=0 (single-level), nothing is presented while a service is active. After `eos_i`, the next chosen pending source is presented.
- R6: With `mode_i`=2, any pending source suspends the running one when the enable is set. `eos_i` then restores the suspended source into `cur_src_o` and lowers `depth_o` by one.
- R7: With `mode_i`=3, only a source with a strictly higher index than `cur_src_o` suspends the running service. Equal or lower sources wait.
- R8: `en_o` is 0 after reset. It is set by `en_set_i` and cleared in the same cycle that `irq_o` rises. No request is presented while `en_o` is 0.
- R9: A pending bit that is not cleared causes the same source to be presented again as soon as the enable is set and the mode allows it.
- R10: The nesting stack holds N entries. A suspension with N entries already stacked drops the push and sets the sticky `ovf_o`. `depth_o` never exceeds N.
- R11: `eos_i` with an empty stack returns to idle (`active_o`=0). When idle, `depth_o` is 0.
- R12: `irq_o` is a one-cycle pulse. `src_o` carries the presented index, and that index becomes `cur_src_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | Service mode: bit1 multi-level, bit0 fixed priority |
| req_i | input | N | Asynchronous request lines |
| sample_i | input | 1 | Sampling instant for the request lines |
| en_set_i | input | 1 | Sets the global enable |
| clr_i | input | N | Per-source clear of pending and lost bits |
| eos_i | input | 1 | End of the current service |
| irq_o | output | 1 | Interrupt pulse to the processor |
| src_o | output | IW | Index of the presented source |
| en_o | output | 1 | Global enable state |
| active_o | output | 1 | A service is in progress |
| cur_src_o | output | IW | Source currently in service |
| pend_o | output | N | Pending bits |
| lost_o | output | N | Lost-occurrence flags |
| depth_o | output | DW | Number of suspended services on the stack |
| ovf_o | output | 1 | Sticky nesting-stack overflow |

## Verification
Some rules are checked by assertions on every cycle. The enable must be clear whenever a pulse goes out, and the pulse lasts one cycle. Single-level modes never present during a service unless that cycle ends it, and preemption in the strictly-higher mode always raises the index. Lost flags stay set until cleared, the overflow flag stays set, depth is bounded and zero when idle, and each pop resumes with one fewer entry. The ordering among simultaneous and staggered arrivals, the synchronizer latency, re-presentation of an uncleared source and the exact resumed index can be shown only by the bench's scenarios.

// File: rtl/nic_pkg.sv
package nic_pkg;
    // mode_i encoding: bit1 = multi-level, bit0 = fixed priority
    typedef enum logic [1:0] {
        MODE_SL_ORDER = 2'd0,
        MODE_SL_PRIO  = 2'd1,
        MODE_ML_ANY   = 2'd2,
        MODE_ML_HIGH  = 2'd3
    } svc_mode_e;

    function automatic logic mode_nests(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic mode_ranked(input logic [1:0] m);
        return m[0];
    endfunction
endpackage

// File: rtl/nic_sync.sv
module nic_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.s2;
endmodule

// File: rtl/nic_order.sv
// Arrival-order tracker: an age matrix where row i, column j set means
// source i was captured before source j.
module nic_order #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] fresh_i,
    output logic [N-1:0] oldest_o
);
    typedef struct packed {
        logic [N-1:0][N-1:0] older;
    } age_t;

    age_t age_d, age_q;

    always_comb begin
        age_d = age_q;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (i == j)                      age_d.older[i][j] = 1'b0;
                else if (fresh_i[i] && fresh_i[j]) age_d.older[i][j] = (i < j);
                else if (fresh_i[i])             age_d.older[i][j] = 1'b0;
                else if (fresh_i[j])             age_d.older[i][j] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_oldest
        logic [N-1:0] beats;
        always_comb begin
            beats    = age_q.older[g] | ~pend_i;
            beats[g] = 1'b1;
        end
        assign oldest_o[g] = pend_i[g] & (&beats);
    end
endmodule

// File: rtl/nic_pick.sv
module nic_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  oldest_i,
    input  logic          ranked_i,
    output logic [IW-1:0] idx_o,
    output logic          vld_o
);
    always_comb begin
        idx_o = '0;
        vld_o = |pend_i;
        if (ranked_i) begin
            for (int i = 0; i < N; i++)
                if (pend_i[i]) idx_o = IW'(i);
        end else begin
            for (int i = N - 1; i >= 0; i--)
                if (oldest_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/nest_intc.sv
module nest_intc #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1,
    parameter int DW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [N-1:0]  req_i,
    input  logic          sample_i,
    input  logic          en_set_i,
    input  logic [N-1:0]  clr_i,
    input  logic          eos_i,
    output logic          irq_o,
    output logic [IW-1:0] src_o,
    output logic          en_o,
    output logic          active_o,
    output logic [IW-1:0] cur_src_o,
    output logic [N-1:0]  pend_o,
    output logic [N-1:0]  lost_o,
    output logic [DW-1:0] depth_o,
    output logic          ovf_o
);
    import nic_pkg::*;

    localparam logic [DW-1:0] FULL = DW'(N);

    typedef struct packed {
        logic [N-1:0]         smp;
        logic [N-1:0]         pend;
        logic [N-1:0]         lost;
        logic                 en;
        logic                 act;
        logic [IW-1:0]        cur;
        logic                 irq;
        logic [IW-1:0]        src;
        logic [N-1:0][IW-1:0] stk;
        logic [DW-1:0]        dep;
        logic                 ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [N-1:0]  req_s;
    logic [N-1:0]  arrive;
    logic [N-1:0]  kept;
    logic [N-1:0]  fresh;
    logic [N-1:0]  oldest;
    logic [IW-1:0] sel_idx;
    logic          sel_vld;
    logic          may_take;
    logic          take;

    nic_sync #(.W(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(req_i),
        .sync_o (req_s)
    );

    nic_order #(.N(N)) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (ctl_q.pend),
        .fresh_i (fresh),
        .oldest_o(oldest)
    );

    nic_pick #(.N(N), .IW(IW)) u_pick (
        .pend_i  (ctl_q.pend),
        .oldest_i(oldest),
        .ranked_i(mode_ranked(mode_i)),
        .idx_o   (sel_idx),
        .vld_o   (sel_vld)
    );

    // capture and pending bookkeeping
    always_comb begin
        arrive = sample_i ? (req_s & ~ctl_q.smp) : '0;
        kept   = ctl_q.pend & ~clr_i;
        fresh  = arrive & ~kept;
    end

    // presentation decision
    always_comb begin
        if (!mode_nests(mode_i))            may_take = !ctl_q.act;
        else if (!mode_ranked(mode_i))      may_take = 1'b1;
        else                                may_take = !ctl_q.act || (sel_idx > ctl_q.cur);
        take = ctl_q.en && sel_vld && !eos_i && may_take;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.irq  = 1'b0;
        if (sample_i) ctl_d.smp = req_s;
        ctl_d.pend = kept | arrive;
        ctl_d.lost = (ctl_q.lost & ~clr_i) | (arrive & kept);

        if (eos_i && ctl_q.act) begin
            if (ctl_q.dep != '0) begin
                ctl_d.cur = ctl_q.stk[IW'(ctl_q.dep - DW'(1))];
                ctl_d.dep = ctl_q.dep - DW'(1);
            end else begin
                ctl_d.act = 1'b0;
            end
        end

        if (take) begin
            ctl_d.irq = 1'b1;
            ctl_d.src = sel_idx;
            ctl_d.cur = sel_idx;
            ctl_d.act = 1'b1;
            ctl_d.en  = 1'b0;
            if (ctl_q.act) begin
                if (ctl_q.dep == FULL) begin
                    ctl_d.ovf = 1'b1;
                end else begin
                    ctl_d.stk[IW'(ctl_q.dep)] = ctl_q.cur;
                    ctl_d.dep = ctl_q.dep + DW'(1);
                end
            end
        end else if (en_set_i) begin
            ctl_d.en = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_o     = ctl_q.irq;
    assign src_o     = ctl_q.src;
    assign en_o      = ctl_q.en;
    assign active_o  = ctl_q.act;
    assign cur_src_o = ctl_q.cur;
    assign pend_o    = ctl_q.pend;
    assign lost_o    = ctl_q.lost;
    assign depth_o   = ctl_q.dep;
    assign ovf_o     = ctl_q.ovf;
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int DW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic [N-1:0]  clr_i,
    input logic          eos_i,
    input logic          irq_o,
    input logic [IW-1:0] src_o,
    input logic          en_o,
    input logic          active_o,
    input logic [IW-1:0] cur_src_o,
    input logic [N-1:0]  lost_o,
    input logic [DW-1:0] depth_o,
    input logic          ovf_o
);
    p_en_before_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(en_o) && !en_o));

    p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_irq_sets_cur_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cur_src_o == src_o));

    p_single_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mode_i[1]) && $past(active_o) && !$past(eos_i)) |-> !irq_o);

    p_higher_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(active_o) && ($past(mode_i) == 2'b11)) |-> (src_o > $past(cur_src_o)));

    p_lost_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(lost_o) & ~$past(clr_i)) & ~lost_o) == '0));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DW'(N));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf_o) |-> ovf_o);

    p_idle_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (depth_o == '0));

    p_resume_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eos_i && active_o && (depth_o != '0)) |-> (active_o && (depth_o == $past(depth_o) - DW'(1))));
endmodule

bind nest_intc nic_checker #(.N(N), .IW(IW), .DW(DW)) u_nic_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .clr_i    (clr_i),
    .eos_i    (eos_i),
    .irq_o    (irq_o),
    .src_o    (src_o),
    .en_o     (en_o),
    .active_o (active_o),
    .cur_src_o(cur_src_o),
    .lost_o   (lost_o),
    .depth_o  (depth_o),
    .ovf_o    (ovf_o)
);

// File: tb/nest_intc_test.sv
module nest_intc_test;
    localparam int N      = 4;
    localparam int IW     = 2;
    localparam int DW     = 3;
    localparam int PERIOD = 10;
    localparam int NVEC   = 8;

    // {mode, first capture mask, second capture mask, expected index}
    localparam bit [11:0] VEC [NVEC] = '{
        {2'd0, 4'b0110, 4'b0000, 2'd1},
        {2'd0, 4'b1000, 4'b0001, 2'd3},
        {2'd0, 4'b0001, 4'b1000, 2'd0},
        {2'd1, 4'b0001, 4'b1000, 2'd3},
        {2'd1, 4'b0110, 4'b0000, 2'd2},
        {2'd2, 4'b1000, 4'b0001, 2'd3},
        {2'd3, 4'b0101, 4'b0000, 2'd2},
        {2'd1, 4'b1111, 4'b0000, 2'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = '0;
    logic [N-1:0]  req_i = '0;
    logic          sample_i = 1'b0;
    logic          en_set_i = 1'b0;
    logic [N-1:0]  clr_i = '0;
    logic          eos_i = 1'b0;
    logic          irq_o;
    logic [IW-1:0] src_o;
    logic          en_o;
    logic          active_o;
    logic [IW-1:0] cur_src_o;
    logic [N-1:0]  pend_o;
    logic [N-1:0]  lost_o;
    logic [DW-1:0] depth_o;
    logic          ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    nest_intc #(.N(N)) uut (.*);

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n = 1'b0; req_i = '0; sample_i = 0; en_set_i = 0; clr_i = '0; eos_i = 0;
        mode_i = m;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic strobe();
        sample_i = 1'b1; cyc(1); sample_i = 1'b0;
    endtask

    task automatic arrive(input logic [N-1:0] m);
        req_i = req_i | m; cyc(3); strobe();
    endtask

    task automatic drop(input logic [N-1:0] m);
        req_i = req_i & ~m; cyc(3); strobe();
    endtask

    task automatic enable();
        en_set_i = 1'b1; cyc(1); en_set_i = 1'b0;
    endtask

    task automatic clear(input logic [N-1:0] m);
        clr_i = m; cyc(1); clr_i = '0;
    endtask

    task automatic end_svc();
        eos_i = 1'b1; cyc(1); eos_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // reset state
        do_reset(2'd0);
        check("R8 reset en", int'(en_o), 0);
        check("R12 reset irq", int'(irq_o), 0);
        check("R11 reset active", int'(active_o), 0);
        check("R2 reset pend", int'(pend_o), 0);
        check("R10 reset ovf", int'(ovf_o), 0);

        // vector table: choice among captured sources
        for (int v = 0; v < NVEC; v++) begin
            do_reset(VEC[v][11:10]);
            arrive(VEC[v][9:6]);
            if (VEC[v][5:2] != 0) arrive(VEC[v][5:2]);
            enable();
            cyc(1);
            check($sformatf("R3/R4 vec%0d irq", v), int'(irq_o), 1);
            check($sformatf("R3/R4 vec%0d src", v), int'(src_o), int'(VEC[v][1:0]));
            check($sformatf("R12 vec%0d cur", v), int'(cur_src_o), int'(VEC[v][1:0]));
            check($sformatf("R8 vec%0d en cleared", v), int'(en_o), 0);
            cyc(1);
            check($sformatf("R12 vec%0d pulse", v), int'(irq_o), 0);
        end

        // R1: synchronizer latency and strobe gating
        do_reset(2'd1);
        req_i = 4'b0001; cyc(5);
        check("R1 no strobe", int'(pend_o), 0);
        req_i = 4'b0011; cyc(1); strobe();
        check("R1 too early", int'(pend_o), 4'b0001);
        strobe();
        check("R1 after sync", int'(pend_o), 4'b0011);

        // R2: lost occurrence and clearing
        drop(4'b0001); arrive(4'b0001);
        check("R2 lost set", int'(lost_o), 4'b0001);
        check("R2 pend kept", int'(pend_o), 4'b0011);
        clear(4'b0001);
        check("R2 pend clr", int'(pend_o), 4'b0010);
        check("R2 lost clr", int'(lost_o), 0);

        // R8: no presentation without enable
        cyc(4);
        check("R8 no enable", int'(active_o), 0);

        // R5, R9: single-level arrival order
        do_reset(2'd0);
        arrive(4'b0001); enable(); cyc(1);
        check("R5 first src", int'(src_o), 0);
        arrive(4'b1000); enable(); cyc(2);
        check("R5 no preempt irq", int'(irq_o), 0);
        check("R5 no preempt cur", int'(cur_src_o), 0);
        clear(4'b0001); end_svc(); cyc(1);
        check("R5 next after eos irq", int'(irq_o), 1);
        check("R5 next after eos src", int'(src_o), 3);
        end_svc(); cyc(2);
        check("R11 idle after eos", int'(active_o), 0);
        check("R8 held off", int'(irq_o), 0);
        enable(); cyc(1);
        check("R9 re-present irq", int'(irq_o), 1);
        check("R9 re-present src", int'(src_o), 3);

        // R6: preempt-any nesting and resume
        do_reset(2'd2);
        arrive(4'b0100); enable(); cyc(1);
        check("R6 first src", int'(src_o), 2);
        clear(4'b0100);
        arrive(4'b0001); enable(); cyc(1);
        check("R6 lower preempts", int'(src_o), 0);
        check("R6 depth", int'(depth_o), 1);
        clear(4'b0001); end_svc();
        check("R6 resumed cur", int'(cur_src_o), 2);
        check("R6 depth popped", int'(depth_o), 0);
        check("R6 still active", int'(active_o), 1);
        end_svc();
        check("R11 idle", int'(active_o), 0);

        // R7: preempt only by strictly higher
        do_reset(2'd3);
        arrive(4'b0100); enable(); cyc(1);
        check("R7 first src", int'(src_o), 2);
        clear(4'b0100);
        arrive(4'b0010); enable(); cyc(2);
        check("R7 lower waits", int'(cur_src_o), 2);
        drop(4'b0100); arrive(4'b0100); cyc(2);
        check("R7 equal waits", int'(cur_src_o), 2);
        check("R7 equal depth", int'(depth_o), 0);
        arrive(4'b1000); cyc(1);
        check("R7 higher irq", int'(irq_o), 1);
        check("R7 higher src", int'(src_o), 3);
        check("R7 depth", int'(depth_o), 1);

        // R10: uncleared source re-enters until the stack is full
        do_reset(2'd2);
        arrive(4'b0001); enable(); cyc(1);
        for (int k = 1; k <= N; k++) begin
            enable(); cyc(1);
            check($sformatf("R10 depth %0d", k), int'(depth_o), k);
        end
        check("R10 no ovf yet", int'(ovf_o), 0);
        enable(); cyc(1);
        check("R10 ovf", int'(ovf_o), 1);
        check("R10 depth capped", int'(depth_o), N);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule